// File: doc/BRIEF.md
# Packet Receive Buffer with Hardware Skip

This block holds received packets between a packet writer and a host. Packet payload goes into a 32-bit word FIFO, and a per-packet status word that carries the byte length goes into a separate status FIFO. The host pops status entries and data words one at a time through single-cycle read strobes. A read strobe returns its word combinationally in the same cycle.

Two self-clearing commands act on the buffer. A skip command drops whatever remains of the packet at the head of the word FIFO. It moves the data read pointer to the first word of the next packet without any host reads, and it leaves the status FIFO untouched. The skip can run while the writer keeps adding packets. A flush command resets the pointers of every queue. It is accepted only while the receiver reports that it is halted.

Internally, a shadow queue of packet lengths tracks how the data side is divided into packets. This lets a skip work even after the host has already popped that packet's status.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset, both FIFOs are empty, both levels are 0, the full flags are 0, and the skip busy, flush busy and both error flags are 0.
- R2: Data words come out at `rd_data_o` in write order, one per cycle in which `data_rd_i` is high. A read of an empty data FIFO returns 0 and leaves the level at 0.
- R3: `data_full_o` is 1 at 512 words. Words written while the FIFO is full are dropped, and the level stays at 512.
- R4: Status entries come out at `stat_rd_o` in write order, each holding the byte length in bits [10:0]. `stat_full_o` is 1 at 32 entries, and writes made while it is full are dropped.
- R5: A skip advances the data read pointer by ceil(length/4) words of the head packet, minus any words of that packet the host has already read. The next read returns the first word of the following packet.
- R6: `skip_busy_o` rises in the cycle after `skip_set_i` and stays high for exactly 2 cycles. The skip takes effect when it falls.
- R7: A data read while `skip_busy_o` is high returns 0 and pops nothing. It also sets `rd_err_o`, which stays set until a flush completes.
- R8: A skip does not change the status FIFO level or its contents.
- R9: Words written while a skip is in progress are kept and are read back in order afterwards.
- R10: A skip requested when no complete packet (data plus status) is at the head is ignored: `skip_busy_o` stays 0 and the data level is unchanged.
- R11: A flush requested while `rx_halted_i` is 1 raises `flush_busy_o` for one cycle. After that cycle, both levels are 0 and both error flags are cleared.
- R12: A flush requested while `rx_halted_i` is 0 is ignored: the levels are unchanged, `flush_busy_o` stays 0, and `flush_err_o` is set and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_halted_i | input | 1 | Receiver halted, required for flush |
| wr_data_valid_i | input | 1 | Writer pushes a data word |
| wr_data_i | input | 32 | Data word from writer |
| wr_stat_valid_i | input | 1 | Writer pushes a packet status |
| wr_stat_len_i | input | 11 | Packet length in bytes |
| data_rd_i | input | 1 | Host data read strobe |
| rd_data_o | output | 32 | Data word for the current read strobe |
| stat_rd_i | input | 1 | Host status read strobe |
| stat_rd_o | output | 11 | Head status length, 0 when empty |
| skip_set_i | input | 1 | Request skip of the head packet |
| skip_busy_o | output | 1 | Skip in progress |
| flush_set_i | input | 1 | Request flush of all queues |
| flush_busy_o | output | 1 | Flush in progress |
| rd_err_o | output | 1 | Sticky: data read during skip |
| flush_err_o | output | 1 | Sticky: flush requested while running |
| data_level_o | output | 10 | Words held in data FIFO |
| data_full_o | output | 1 | Data FIFO full |
| data_empty_o | output | 1 | Data FIFO empty |
| stat_level_o | output | 6 | Entries held in status FIFO |
| stat_full_o | output | 1 | Status path full |
| stat_empty_o | output | 1 | Status FIFO empty |

## Verification
A wrong packet-length shadow entry or a wrong per-packet read count does not show at once. It shows one skip later, when `data_level_o` settles to the wrong value and the next `rd_data_o` is a word from the middle of a packet instead of a packet's first word. A stuck skip counter shows in the first skip, because `skip_busy_o` is high for the wrong number of cycles. Pointer corruption shows in the level outputs in the cycle after it occurs. For these reasons, the bench compares levels and the first word after every skip, and it mixes partial reads with skips.

// File: rtl/rx_pkt_pkg.sv
package rx_pkt_pkg;
  localparam int unsigned WORD_BYTES = 4;

  function automatic int unsigned bytes_to_words(input int unsigned len_b);
    return (len_b + WORD_BYTES - 1) / WORD_BYTES;
  endfunction
endpackage

// File: rtl/rx_ptr_fifo.sv
module rx_ptr_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [LW-1:0] adv_i,
  output logic [W-1:0]  head_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [LW-1:0] wptr_q, rptr_q;
  logic          push_ok;

  assign level_o = wptr_q - rptr_q;
  assign push_ok = push_i && (level_o != LW'(DEPTH)) && !clr_i;
  assign head_o  = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + LW'(1);
      rptr_q <= rptr_q + adv_i;
    end
  end
endmodule

// File: rtl/rx_skip_ctrl.sv
module rx_skip_ctrl #(
  parameter int unsigned LW       = 10,
  parameter int unsigned LEN_W    = 11,
  parameter int unsigned SKIP_CYC = 2,
  localparam int unsigned CW      = $clog2(SKIP_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             skip_req_i,
  input  logic             host_pop_i,
  input  logic             pkt_valid_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  output logic             busy_o,
  output logic [LW-1:0]    adv_o,
  output logic             pkt_pop_o
);
  logic [LW-1:0]  rd_cnt_q, rd_cnt_d, cnt_sum, pkt_words;
  logic [LEN_W:0] len_rnd;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, done, auto_pop, start;

  assign len_rnd   = {1'b0, pkt_len_i} + (LEN_W+1)'(3);
  assign pkt_words = LW'(len_rnd >> 2);
  assign cnt_sum   = rd_cnt_q + LW'(host_pop_i);
  assign done      = busy_q && (cnt_q == '0);
  // head packet fully consumed by host reads
  assign auto_pop  = !busy_q && pkt_valid_i && (cnt_sum >= pkt_words);
  assign start     = skip_req_i && !busy_q && pkt_valid_i && !auto_pop;
  assign busy_o    = busy_q;

  always_comb begin
    pkt_pop_o = 1'b0;
    adv_o     = LW'(host_pop_i);
    rd_cnt_d  = cnt_sum;
    if (done) begin
      pkt_pop_o = 1'b1;
      adv_o     = pkt_words - rd_cnt_q;
      rd_cnt_d  = '0;
    end else if (auto_pop) begin
      pkt_pop_o = 1'b1;
      rd_cnt_d  = cnt_sum - pkt_words;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      rd_cnt_q <= '0;
    end else if (clr_i) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      rd_cnt_q <= '0;
    end else begin
      rd_cnt_q <= rd_cnt_d;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(SKIP_CYC - 1);
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DATA_DEPTH = 512,
  parameter int unsigned STAT_DEPTH = 32,
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned SKIP_CYC   = 2,
  localparam int unsigned DLW       = $clog2(DATA_DEPTH) + 1,
  localparam int unsigned SLW       = $clog2(STAT_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_halted_i,
  input  logic              wr_data_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_stat_valid_i,
  input  logic [LEN_W-1:0]  wr_stat_len_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              stat_rd_i,
  output logic [LEN_W-1:0]  stat_rd_o,
  input  logic              skip_set_i,
  output logic              skip_busy_o,
  input  logic              flush_set_i,
  output logic              flush_busy_o,
  output logic              rd_err_o,
  output logic              flush_err_o,
  output logic [DLW-1:0]    data_level_o,
  output logic              data_full_o,
  output logic              data_empty_o,
  output logic [SLW-1:0]    stat_level_o,
  output logic              stat_full_o,
  output logic              stat_empty_o
);
  logic              flush_q, rd_err_q, flush_err_q;
  logic              host_pop, stat_pop, stat_push, pkt_pop, lenq_full, lenq_empty;
  logic [DATA_W-1:0] data_head;
  logic [LEN_W-1:0]  stat_head, lenq_head;
  logic [SLW-1:0]    lenq_level;
  logic [DLW-1:0]    data_adv;

  assign data_full_o  = data_level_o == DLW'(DATA_DEPTH);
  assign data_empty_o = data_level_o == '0;
  assign stat_empty_o = stat_level_o == '0;
  assign lenq_full    = lenq_level == SLW'(STAT_DEPTH);
  assign lenq_empty   = lenq_level == '0;
  // status path is full when either the host queue or the shadow queue is
  assign stat_full_o  = (stat_level_o == SLW'(STAT_DEPTH)) || lenq_full;

  assign host_pop  = data_rd_i && !skip_busy_o && !data_empty_o && !flush_q;
  assign stat_pop  = stat_rd_i && !stat_empty_o && !flush_q;
  assign stat_push = wr_stat_valid_i && !stat_full_o;

  assign rd_data_o    = host_pop ? data_head : '0;
  assign stat_rd_o    = stat_empty_o ? '0 : stat_head;
  assign flush_busy_o = flush_q;
  assign rd_err_o     = rd_err_q;
  assign flush_err_o  = flush_err_q;

  rx_ptr_fifo #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data (
    .clk_i, .rst_ni, .clr_i(flush_q),
    .push_i(wr_data_valid_i), .wdata_i(wr_data_i), .adv_i(data_adv),
    .head_o(data_head), .level_o(data_level_o)
  );

  rx_ptr_fifo #(.W(LEN_W), .DEPTH(STAT_DEPTH)) u_stat (
    .clk_i, .rst_ni, .clr_i(flush_q),
    .push_i(stat_push), .wdata_i(wr_stat_len_i), .adv_i(SLW'(stat_pop)),
    .head_o(stat_head), .level_o(stat_level_o)
  );

  // packet lengths as seen by the data side, independent of host status pops
  rx_ptr_fifo #(.W(LEN_W), .DEPTH(STAT_DEPTH)) u_lenq (
    .clk_i, .rst_ni, .clr_i(flush_q),
    .push_i(stat_push), .wdata_i(wr_stat_len_i), .adv_i(SLW'(pkt_pop)),
    .head_o(lenq_head), .level_o(lenq_level)
  );

  rx_skip_ctrl #(.LW(DLW), .LEN_W(LEN_W), .SKIP_CYC(SKIP_CYC)) u_skip (
    .clk_i, .rst_ni, .clr_i(flush_q),
    .skip_req_i(skip_set_i), .host_pop_i(host_pop),
    .pkt_valid_i(!lenq_empty), .pkt_len_i(lenq_head),
    .busy_o(skip_busy_o), .adv_o(data_adv), .pkt_pop_o(pkt_pop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q     <= 1'b0;
      rd_err_q    <= 1'b0;
      flush_err_q <= 1'b0;
    end else begin
      flush_q <= flush_set_i && rx_halted_i && !flush_q;
      if (flush_q) begin
        rd_err_q    <= 1'b0;
        flush_err_q <= 1'b0;
      end else begin
        if (data_rd_i && skip_busy_o)        rd_err_q    <= 1'b1;
        if (flush_set_i && !rx_halted_i)     flush_err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DATA_DEPTH = 512,
  parameter int unsigned STAT_DEPTH = 32,
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned SKIP_CYC   = 2,
  localparam int unsigned DLW       = $clog2(DATA_DEPTH) + 1,
  localparam int unsigned SLW       = $clog2(STAT_DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_halted_i,
  input logic              wr_data_valid_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wr_stat_valid_i,
  input logic [LEN_W-1:0]  wr_stat_len_i,
  input logic              data_rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              stat_rd_i,
  input logic [LEN_W-1:0]  stat_rd_o,
  input logic              skip_set_i,
  input logic              skip_busy_o,
  input logic              flush_set_i,
  input logic              flush_busy_o,
  input logic              rd_err_o,
  input logic              flush_err_o,
  input logic [DLW-1:0]    data_level_o,
  input logic              data_full_o,
  input logic              data_empty_o,
  input logic [SLW-1:0]    stat_level_o,
  input logic              stat_full_o,
  input logic              stat_empty_o
);
  logic [7:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_cnt_q <= '0;
    else if (skip_busy_o) busy_cnt_q <= busy_cnt_q + 8'd1;
    else                  busy_cnt_q <= '0;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_full_o && wr_data_valid_i && !data_rd_i && !skip_busy_o && !flush_busy_o
    |=> data_level_o == DLW'(DATA_DEPTH));

  assert_skip_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(skip_busy_o) && !$past(flush_busy_o) |-> busy_cnt_q == 8'(SKIP_CYC));

  assert_rd_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && skip_busy_o && !flush_busy_o |=> rd_err_o);

  assert_stat_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_busy_o && !stat_rd_i && !wr_stat_valid_i && !flush_busy_o
    |=> stat_level_o == $past(stat_level_o));

  assert_flush_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_busy_o) |-> data_empty_o && stat_empty_o && !rd_err_o && !flush_err_o);

  assert_flush_refused_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_set_i && !rx_halted_i && !flush_busy_o |=> flush_err_o && !flush_busy_o);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(
  .DATA_W(DATA_W), .DATA_DEPTH(DATA_DEPTH), .STAT_DEPTH(STAT_DEPTH),
  .LEN_W(LEN_W), .SKIP_CYC(SKIP_CYC)
) u_chk (.*);

// File: tb/sim_rx_pkt_fifo.sv
module sim_rx_pkt_fifo;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        rx_halted_i = 1'b0, wr_data_valid_i = 1'b0, wr_stat_valid_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [10:0] wr_stat_len_i = '0;
  logic        data_rd_i = 1'b0, stat_rd_i = 1'b0, skip_set_i = 1'b0, flush_set_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [10:0] stat_rd_o;
  logic        skip_busy_o, flush_busy_o, rd_err_o, flush_err_o;
  logic [9:0]  data_level_o;
  logic [5:0]  stat_level_o;
  logic        data_full_o, data_empty_o, stat_full_o, stat_empty_o;

  int checks = 0, errors = 0, word_id = 0, rdc = 0;
  logic [31:0] dq[$];
  int          lq[$];
  int          sq[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rx_pkt_fifo u0 (
    .clk_i(clk), .rst_ni, .rx_halted_i, .wr_data_valid_i, .wr_data_i,
    .wr_stat_valid_i, .wr_stat_len_i, .data_rd_i, .rd_data_o, .stat_rd_i,
    .stat_rd_o, .skip_set_i, .skip_busy_o, .flush_set_i, .flush_busy_o,
    .rd_err_o, .flush_err_o, .data_level_o, .data_full_o, .data_empty_o,
    .stat_level_o, .stat_full_o, .stat_empty_o
  );

  function automatic int words_of(input int len_b);
    return (len_b + 3) / 4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w, input bit model);
    @(negedge clk);
    wr_data_valid_i = 1'b1; wr_data_i = w;
    if (model && dq.size() < 512) dq.push_back(w);
    @(posedge clk); #1 wr_data_valid_i = 1'b0;
  endtask

  task automatic write_stat(input int len_b, input bit to_lq);
    @(negedge clk);
    wr_stat_valid_i = 1'b1; wr_stat_len_i = 11'(len_b);
    if (sq.size() < 32) begin
      sq.push_back(len_b);
      if (to_lq) lq.push_back(len_b);
    end
    @(posedge clk); #1 wr_stat_valid_i = 1'b0;
  endtask

  task automatic write_packet(input int nw, input int len_b);
    for (int i = 0; i < nw; i++) begin
      word_id++;
      write_word({8'hA5, 24'(word_id)}, 1'b1);
    end
    write_stat(len_b, 1'b1);
  endtask

  task automatic read_word(input string req);
    logic [31:0] exp;
    exp = (dq.size() > 0) ? dq[0] : 32'h0;
    @(negedge clk);
    data_rd_i = 1'b1;
    #1 chk(req, rd_data_o, exp);
    if (dq.size() > 0) begin
      void'(dq.pop_front());
      rdc++;
      if (lq.size() > 0 && rdc >= words_of(lq[0])) begin
        rdc -= words_of(lq[0]);
        void'(lq.pop_front());
      end
    end
    @(posedge clk); #1 data_rd_i = 1'b0;
  endtask

  task automatic read_stat(input string req);
    int exp;
    exp = (sq.size() > 0) ? sq.pop_front() : 0;
    @(negedge clk);
    stat_rd_i = 1'b1;
    #1 chk(req, 32'(stat_rd_o), 32'(exp));
    @(posedge clk); #1 stat_rd_i = 1'b0;
  endtask

  task automatic model_skip();
    int adv;
    adv = words_of(lq[0]) - rdc;
    for (int i = 0; i < adv; i++) void'(dq.pop_front());
    void'(lq.pop_front());
    rdc = 0;
  endtask

  // read_in_busy: issue a data read during the busy window (R7)
  task automatic skip_op(input bit lvl_chk, input bit read_in_busy);
    int n = 0;
    int slvl;
    slvl = sq.size();
    @(negedge clk); skip_set_i = 1'b1;
    @(posedge clk); #1 skip_set_i = 1'b0;
    if (read_in_busy) begin
      @(negedge clk);
      data_rd_i = 1'b1;
      #1 chk("R7 read during skip", rd_data_o, 32'h0);
      @(posedge clk); #1 data_rd_i = 1'b0;
      n = 1;
      @(negedge clk);
      chk("R7 rd_err set", 32'(rd_err_o), 32'h1);
    end else begin
      @(negedge clk);
    end
    while (skip_busy_o && n < 10) begin n++; @(negedge clk); end
    chk("R6 skip busy cycles", 32'(n), 32'd2);
    model_skip();
    if (lvl_chk) begin
      chk("R5 level after skip", 32'(data_level_o), 32'(dq.size()));
      chk("R8 status level kept", 32'(stat_level_o), 32'(slvl));
    end
  endtask

  task automatic flush_op(input bit halted);
    int dl;
    dl = 32'(data_level_o);
    rx_halted_i = halted;
    @(negedge clk); flush_set_i = 1'b1;
    @(posedge clk); #1 flush_set_i = 1'b0;
    @(negedge clk);
    if (halted) begin
      chk("R11 flush busy", 32'(flush_busy_o), 32'h1);
      @(negedge clk);
      chk("R11 data level 0", 32'(data_level_o), 32'h0);
      chk("R11 stat level 0", 32'(stat_level_o), 32'h0);
      chk("R11 errors cleared", {30'h0, rd_err_o, flush_err_o}, 32'h0);
      dq.delete(); lq.delete(); sq.delete(); rdc = 0;
    end else begin
      chk("R12 no flush busy", 32'(flush_busy_o), 32'h0);
      chk("R12 flush_err set", 32'(flush_err_o), 32'h1);
      chk("R12 level kept", 32'(data_level_o), 32'(dl));
    end
    rx_halted_i = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #23 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data level", 32'(data_level_o), 32'h0);
    chk("R1 stat level", 32'(stat_level_o), 32'h0);
    chk("R1 flags", {26'h0, data_empty_o, stat_empty_o, data_full_o, stat_full_o,
        skip_busy_o, flush_busy_o}, 32'h30);
    chk("R1 errors", {30'h0, rd_err_o, flush_err_o}, 32'h0);

    // R2 empty read
    read_word("R2 empty read");
    chk("R2 empty level", 32'(data_level_o), 32'h0);

    // R2/R4 plain packet read
    write_packet(5, 19);
    read_stat("R4 status length");
    for (int i = 0; i < 5; i++) read_word("R2 in-order word");

    // R5 partial read then skip
    write_packet(8, 30);
    write_packet(4, 16);
    read_word("R2 first word");
    read_word("R2 second word");
    skip_op(1'b1, 1'b0);
    read_word("R5 first word of next packet");
    read_stat("R8 status survives skip");
    read_stat("R8 second status");

    // R7 read during busy, then R12/R11 error handling
    write_packet(6, 24);
    skip_op(1'b1, 1'b1);
    flush_op(1'b0);
    flush_op(1'b1);

    // R9 skip while writer is active
    write_packet(6, 21);
    fork
      begin
        for (int i = 0; i < 7; i++) begin
          word_id++;
          write_word({8'hA5, 24'(word_id)}, 1'b1);
        end
        write_stat(28, 1'b1);
      end
      begin repeat (2) @(negedge clk); skip_op(1'b0, 1'b0); end
    join
    @(negedge clk);
    chk("R9 level after concurrent skip", 32'(data_level_o), 32'(dq.size()));
    for (int i = 0; i < 7; i++) read_word("R9 word kept");
    flush_op(1'b1);

    // R10 skip with no complete packet
    for (int i = 0; i < 3; i++) write_word(32'hC0DE_0000 + 32'(i), 1'b1);
    @(negedge clk); skip_set_i = 1'b1;
    @(posedge clk); #1 skip_set_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 no busy", 32'(skip_busy_o), 32'h0);
    end
    chk("R10 level kept", 32'(data_level_o), 32'd3);
    flush_op(1'b1);

    // R3 data full
    for (int i = 0; i < 515; i++) write_word(32'(i), 1'b1);
    @(negedge clk);
    chk("R3 level at full", 32'(data_level_o), 32'd512);
    chk("R3 full flag", 32'(data_full_o), 32'h1);
    read_word("R3 oldest word kept");
    flush_op(1'b1);

    // R4 status full
    for (int i = 0; i < 33; i++) write_stat(i, 1'b0);
    @(negedge clk);
    chk("R4 stat level at full", 32'(stat_level_o), 32'd32);
    chk("R4 stat full flag", 32'(stat_full_o), 32'h1);
    read_stat("R4 oldest status");
    flush_op(1'b1);

    // random packets, consumed by reads, skips or partial reads
    for (int it = 0; it < 40; it++) begin
      int np;
      np = 1 + int'($urandom % 2);
      for (int p = 0; p < np; p++) begin
        int nw;
        nw = 4 + int'($urandom % 21);
        if (dq.size() < 400) write_packet(nw, 4 * nw - int'($urandom % 4));
      end
      if (lq.size() > 0) begin
        int mode;
        read_stat("R4 random status");
        mode = int'($urandom % 3);
        if (mode == 0) begin
          int nw;
          nw = words_of(lq[0]) - rdc;
          for (int i = 0; i < nw; i++) read_word("R2 random read");
        end else if (mode == 1) begin
          skip_op(1'b1, 1'b0);
        end else begin
          read_word("R5 random partial");
          skip_op(1'b1, 1'b0);
        end
      end
    end
    @(negedge clk);
    chk("R5 final level", 32'(data_level_o), 32'(dq.size()));
    while (dq.size() > 0) read_word("R2 drain");
    done = 1'b1;
    report();
  end
endmodule